// File: doc/BRIEF.md
# Debug Step Event Controller

This block watches the instruction retire stream of a small processor core and decides, one retirement at a time, whether a stepping event must stop the core. Two stepping sources exist. Completion stepping fires after ordinary instructions. Branch stepping fires after taken branches. When the core is built with debug-enable support and the debug-enable bit of the machine state is set, both sources are armed from a software-visible control register. In every other case only the machine-state branch-trace bit can arm branch stepping, and completion stepping is off.

An event in debug-enable mode first records its cause in a sticky status register. It then raises a debug interrupt request and copies the return address and the machine state into two save registers. An event in the other mode raises a plain branch-trace request that leaves the status and save registers alone. The request is held until the core acknowledges it. All four registers are reached through a small read/write port whose read data is combinational.

The request logic is a two-state machine. `ST_IDLE` leaves on transition *fire* (a retirement that qualifies as an event) to `ST_HOLD`, which drives the request. `ST_HOLD` returns on transition *ack* (the acknowledge input) to `ST_IDLE`.

Top module: `dbg_step_ctrl`

## Requirements
- R1: After reset the request output is low, and the control, status, saved-address and saved-state registers all read zero.
- R2: In debug-enable mode (strap high and `msr_de` high), completion stepping is armed by control bit 27 and branch stepping by control bit 26. `msr_be` has no effect in this mode.
- R3: Outside debug-enable mode, `msr_be` arms branch stepping of taken branches and completion stepping is off. The resulting request has `evt_is_dbg` low and changes neither the status register nor the save registers.
- R4: A non-branch instruction flagged as syscall or trap never raises a completion event.
- R5: Branch instructions are classified only on the branch path. With completion stepping armed, any branch (taken or not) gives a trace event, even when branch stepping is also armed. Otherwise only a taken branch with branch stepping armed gives a branch event. A retirement raises at most one cause.
- R6: A debug-enable-mode event sets status bit 27 (trace) or bit 26 (branch) on the same edge that raises the request. Status bits are sticky. Writing 1 clears a bit, writing 0 leaves it. A set and a clear on the same edge leave the bit set.
- R7: The return address is the branch target for a taken branch and retire PC + `INSN_BYTES` otherwise. The saved state is `msr_val`. In debug-enable mode both are loaded into the save registers, and this capture wins over a software write in the same cycle.
- R8: A control-register write is seen by retirements from the next cycle on. A retirement in the same cycle as the write uses the old value.
- R9: The request, once raised, stays high with a stable return address until `evt_ack`. Retirements while the request is held are ignored and do not touch the status register. `evt_ack` while idle has no effect.
- R10: Register map by `reg_addr`: 0 is control (32-bit read/write), 1 is status (only bits 27 and 26 exist, the rest read 0), 2 is saved address (read/write), 3 is saved state (read/write).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ret_vld | input | 1 | An instruction retires this cycle |
| ret_is_br | input | 1 | The retiring instruction is a branch |
| ret_taken | input | 1 | The branch was taken |
| ret_is_sc | input | 1 | The retiring instruction is a syscall |
| ret_is_trap | input | 1 | The retiring instruction is a trap |
| ret_pc | input | AW | Address of the retiring instruction |
| ret_tgt | input | AW | Branch target address |
| msr_val | input | MW | Current machine state word |
| msr_de | input | 1 | Machine-state debug-enable bit |
| msr_be | input | 1 | Machine-state branch-trace bit |
| de_strap | input | 1 | Core supports debug-enable mode |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| evt_req | output | 1 | Stepping request, held until acknowledged |
| evt_is_dbg | output | 1 | Request is a debug interrupt (high) or a branch-trace exception (low) |
| evt_ret | output | AW | Return address of the request |
| evt_msr | output | MW | Machine state saved with the request |
| evt_ack | input | 1 | Core acknowledges the request |

## Verification
The hardest situations to reach are the same-edge collisions. One is a software write to the control, status or saved-address register landing in the very cycle an event retires. The other is a retirement arriving while an earlier request is still held. The bench sets each one up by driving the register strobe and the retire strobe together before a single clock edge. It does the same with a retirement issued between fire and acknowledge, and reads the registers back through the port before anything else can change them. A vector table sweeps the mode, enable and instruction-class combinations that decide trace versus branch versus nothing.

// File: rtl/dbg_step_pkg.sv
package dbg_step_pkg;

    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_TRACE  = 2'd1,
        EV_BRANCH = 2'd2
    } ev_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } req_state_e;

    localparam int unsigned TRACE_BIT  = 27;
    localparam int unsigned BRANCH_BIT = 26;
    localparam int unsigned REG_W      = 32;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_STAT = 2'd1;
    localparam logic [1:0] RA_SPC  = 2'd2;
    localparam logic [1:0] RA_SMSR = 2'd3;

endpackage

// File: rtl/dbg_ev_classify.sv
module dbg_ev_classify
    import dbg_step_pkg::*;
#(
    parameter int unsigned AW         = 32,
    parameter int unsigned INSN_BYTES = 4
) (
    input  logic          de_strap,
    input  logic          msr_de,
    input  logic          msr_be,
    input  logic          ctl_ic,
    input  logic          ctl_bt,
    input  logic          is_br,
    input  logic          taken,
    input  logic          is_sc,
    input  logic          is_trap,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] tgt,
    output ev_kind_e      kind,
    output logic          is_dbg,
    output logic [AW-1:0] ret_addr
);
    localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);

    logic de_mode;
    logic ic_en;
    logic bt_en;

    always_comb begin
        de_mode = de_strap & msr_de;
        ic_en   = de_mode & ctl_ic;
        bt_en   = de_mode ? ctl_bt : msr_be;
        is_dbg  = de_mode;

        kind = EV_NONE;
        if (is_br) begin
            // completion stepping outranks branch stepping on a branch
            if (ic_en)
                kind = EV_TRACE;
            else if (bt_en && taken)
                kind = EV_BRANCH;
        end else if (ic_en && !is_sc && !is_trap) begin
            kind = EV_TRACE;
        end

        ret_addr = (is_br && taken) ? tgt : (pc + STEP);
    end

endmodule

// File: rtl/dbg_regfile.sv
module dbg_regfile
    import dbg_step_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned MW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             set_dbg,
    input  ev_kind_e         set_kind,
    input  logic [AW-1:0]    cap_ret,
    input  logic [MW-1:0]    cap_msr,
    output logic             ctl_ic,
    output logic             ctl_bt
);
    localparam int unsigned NCAUSE = 2;

    logic [REG_W-1:0]  ctrl_q;
    logic [NCAUSE-1:0] stat_q;
    logic [AW-1:0]     spc_q;
    logic [MW-1:0]     smsr_q;
    logic [NCAUSE-1:0] set_vec;

    logic wr_ctrl, wr_stat, wr_spc, wr_smsr;

    always_comb begin
        wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
        wr_stat = reg_wr && (reg_addr == RA_STAT);
        wr_spc  = reg_wr && (reg_addr == RA_SPC);
        wr_smsr = reg_wr && (reg_addr == RA_SMSR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_ctrl)
            ctrl_q <= reg_wdata;
    end

    assign ctl_ic = ctrl_q[TRACE_BIT];
    assign ctl_bt = ctrl_q[BRANCH_BIT];

    // one sticky cause bit per event kind; index 0 is branch, 1 is trace
    for (genvar g = 0; g < NCAUSE; g++) begin : g_cause
        localparam int unsigned POS = (g == 0) ? BRANCH_BIT : TRACE_BIT;
        localparam ev_kind_e    KND = (g == 0) ? EV_BRANCH : EV_TRACE;

        logic clr;
        assign clr        = wr_stat && reg_wdata[POS];
        assign set_vec[g] = set_dbg && (set_kind == KND);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                stat_q[g] <= 1'b0;
            else
                stat_q[g] <= (stat_q[g] && !clr) || set_vec[g];
        end

        p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_q[g] && !clr) |=> stat_q[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spc_q  <= '0;
            smsr_q <= '0;
        end else if (set_dbg) begin
            spc_q  <= cap_ret;
            smsr_q <= cap_msr;
        end else begin
            if (wr_spc)
                spc_q <= reg_wdata[AW-1:0];
            if (wr_smsr)
                smsr_q <= reg_wdata[MW-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_CTRL: reg_rdata = ctrl_q;
            RA_STAT: begin
                reg_rdata[BRANCH_BIT] = stat_q[0];
                reg_rdata[TRACE_BIT]  = stat_q[1];
            end
            RA_SPC:  reg_rdata[AW-1:0] = spc_q;
            RA_SMSR: reg_rdata[MW-1:0] = smsr_q;
            default: reg_rdata = '0;
        endcase
    end

    p_one_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_vec));

    p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_dbg |=> (spc_q == $past(cap_ret)) && (smsr_q == $past(cap_msr)));

endmodule

// File: rtl/dbg_req_fsm.sv
module dbg_req_fsm
    import dbg_step_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned MW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ret_vld,
    input  ev_kind_e      kind,
    input  logic          is_dbg,
    input  logic [AW-1:0] ret_addr,
    input  logic [MW-1:0] msr,
    input  logic          ack,
    output logic          fire,
    output logic          req,
    output logic          req_dbg,
    output logic [AW-1:0] req_ret,
    output logic [MW-1:0] req_msr
);
    req_state_e    state_q, state_d;
    logic          dbg_q;
    logic [AW-1:0] ret_q;
    logic [MW-1:0] msr_q;

    always_comb begin
        fire    = 1'b0;
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                fire = ret_vld && (kind != EV_NONE);
                if (fire)
                    state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (ack)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dbg_q   <= 1'b0;
            ret_q   <= '0;
            msr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (fire) begin
                dbg_q <= is_dbg;
                ret_q <= ret_addr;
                msr_q <= msr;
            end
        end
    end

    always_comb begin
        req     = 1'b0;
        req_dbg = 1'b0;
        unique case (state_q)
            ST_IDLE: req = 1'b0;
            ST_HOLD: begin
                req     = 1'b1;
                req_dbg = dbg_q;
            end
            default: req = 1'b0;
        endcase
        req_ret = ret_q;
        req_msr = msr_q;
    end

    p_hold_until_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> (req && $stable(req_ret) && $stable(req_msr)));

    p_rise_from_retire_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> $past(ret_vld));

endmodule

// File: rtl/dbg_step_ctrl.sv
module dbg_step_ctrl
    import dbg_step_pkg::*;
#(
    parameter int unsigned AW         = 32,
    parameter int unsigned MW         = 32,
    parameter int unsigned INSN_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ret_vld,
    input  logic             ret_is_br,
    input  logic             ret_taken,
    input  logic             ret_is_sc,
    input  logic             ret_is_trap,
    input  logic [AW-1:0]    ret_pc,
    input  logic [AW-1:0]    ret_tgt,
    input  logic [MW-1:0]    msr_val,
    input  logic             msr_de,
    input  logic             msr_be,
    input  logic             de_strap,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             evt_req,
    output logic             evt_is_dbg,
    output logic [AW-1:0]    evt_ret,
    output logic [MW-1:0]    evt_msr,
    input  logic             evt_ack
);
    ev_kind_e      kind;
    logic          is_dbg;
    logic [AW-1:0] ret_addr;
    logic          ctl_ic, ctl_bt;
    logic          fire;
    logic          set_dbg;

    dbg_ev_classify #(.AW(AW), .INSN_BYTES(INSN_BYTES)) u_cls (
        .de_strap (de_strap),
        .msr_de   (msr_de),
        .msr_be   (msr_be),
        .ctl_ic   (ctl_ic),
        .ctl_bt   (ctl_bt),
        .is_br    (ret_is_br),
        .taken    (ret_taken),
        .is_sc    (ret_is_sc),
        .is_trap  (ret_is_trap),
        .pc       (ret_pc),
        .tgt      (ret_tgt),
        .kind     (kind),
        .is_dbg   (is_dbg),
        .ret_addr (ret_addr)
    );

    dbg_req_fsm #(.AW(AW), .MW(MW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ret_vld  (ret_vld),
        .kind     (kind),
        .is_dbg   (is_dbg),
        .ret_addr (ret_addr),
        .msr      (msr_val),
        .ack      (evt_ack),
        .fire     (fire),
        .req      (evt_req),
        .req_dbg  (evt_is_dbg),
        .req_ret  (evt_ret),
        .req_msr  (evt_msr)
    );

    assign set_dbg = fire && is_dbg;

    dbg_regfile #(.AW(AW), .MW(MW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .set_dbg   (set_dbg),
        .set_kind  (kind),
        .cap_ret   (ret_addr),
        .cap_msr   (msr_val),
        .ctl_ic    (ctl_ic),
        .ctl_bt    (ctl_bt)
    );

    p_legacy_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !is_dbg) |=> (evt_req && !evt_is_dbg));

endmodule

// File: tb/tb_dbg_step_ctrl.sv
`timescale 1ns/1ps
module tb_dbg_step_ctrl;
    localparam int AW = 32;
    localparam int MW = 32;
    localparam int NV = 13;
    localparam logic [31:0] B27 = 32'h0800_0000;
    localparam logic [31:0] B26 = 32'h0400_0000;

    // fields: ds md mb ic bt br tk sc tr | req dbg tgt s27 s26
    localparam logic [13:0] VEC [NV] = '{
        14'b11010000011010, 14'b11001110011101, 14'b11011110011110,
        14'b11001100000000, 14'b11100110000000, 14'b11010001000000,
        14'b11010000100000, 14'b01100110010100, 14'b10110000000000,
        14'b10100110010100, 14'b11010100011010, 14'b11000110000000,
        14'b00011110000000
    };

    logic clk = 0, rst_n = 0;
    logic ret_vld = 0, ret_is_br = 0, ret_taken = 0, ret_is_sc = 0, ret_is_trap = 0;
    logic [AW-1:0] ret_pc = '0, ret_tgt = '0;
    logic [MW-1:0] msr_val = '0;
    logic msr_de = 0, msr_be = 0, de_strap = 0;
    logic reg_wr = 0;
    logic [1:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic evt_req, evt_is_dbg, evt_ack = 0;
    logic [AW-1:0] evt_ret;
    logic [MW-1:0] evt_msr;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dbg_step_ctrl #(.AW(AW), .MW(MW), .INSN_BYTES(4)) dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        ret_vld = 0; reg_wr = 0; evt_ack = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick();
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic retire(input logic br, input logic tk, input logic [31:0] pc,
                          input logic [31:0] tg, input logic [31:0] m);
        ret_vld = 1; ret_is_br = br; ret_taken = tk; ret_is_sc = 0; ret_is_trap = 0;
        ret_pc = pc; ret_tgt = tg; msr_val = m;
    endtask

    task automatic do_ack();
        evt_ack = 1;
        tick();
    endtask

    function automatic string tag_of(input int i);
        case (i)
            0: return "R2 completion step";
            1: return "R2 branch step";
            2: return "R5 trace over branch";
            3: return "R5 untaken branch";
            4: return "R2 msr_be ignored";
            5: return "R4 syscall";
            6: return "R4 trap";
            7: return "R3 no strap";
            8: return "R3 no completion";
            9: return "R3 legacy branch";
            10: return "R5 untaken trace";
            11: return "R5 nothing armed";
            default: return "R3 nothing armed";
        endcase
    endfunction

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] exp_ret;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 req", {31'b0, evt_req}, 0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            chk("R1 reg", d, 0);
        end
        rst_n = 1;
        tick();

        // vector table
        for (int i = 0; i < NV; i++) begin
            logic [13:0] v;
            v = VEC[i];
            wr(0, (v[10] ? B27 : 0) | (v[9] ? B26 : 0));
            wr(1, 32'hFFFF_FFFF);
            wr(2, 32'hDEAD_0000);
            wr(3, 32'h0BAD_0000);
            de_strap = v[13]; msr_de = v[12]; msr_be = v[11];
            ret_vld = 1; ret_is_br = v[8]; ret_taken = v[7]; ret_is_sc = v[6]; ret_is_trap = v[5];
            ret_pc = 32'h1000 + 32'(i) * 16; ret_tgt = 32'h8000 + 32'(i) * 32;
            msr_val = 32'h5A00 + 32'(i);
            exp_ret = v[2] ? ret_tgt : ret_pc + 4;
            tick();
            chk(tag_of(i), {31'b0, evt_req}, {31'b0, v[4]});
            if (v[4]) begin
                chk(tag_of(i), {31'b0, evt_is_dbg}, {31'b0, v[3]});
                chk({tag_of(i), " R7 ret"}, evt_ret, exp_ret);
                chk({tag_of(i), " R7 msr"}, evt_msr, msr_val);
            end
            rd(1, d);
            chk({tag_of(i), " R6 status"}, d, (v[1] ? B27 : 0) | (v[0] ? B26 : 0));
            rd(2, d);
            chk({tag_of(i), " R7 save addr"}, d, v[3] ? exp_ret : 32'hDEAD_0000);
            rd(3, d);
            chk({tag_of(i), " R7 save msr"}, d, v[3] ? msr_val : 32'h0BAD_0000);
            if (evt_req) begin
                do_ack();
                chk("R9 ack drops req", {31'b0, evt_req}, 0);
            end
        end

        de_strap = 1; msr_de = 1; msr_be = 0;

        // R10 control register full width
        wr(0, 32'hA5A5_A5A5);
        rd(0, d);
        chk("R10 ctrl rw", d, 32'hA5A5_A5A5);
        wr(0, 0);
        wr(1, 32'hFFFF_FFFF);

        // R8 write lands with retire in same cycle: old value used
        retire(0, 0, 32'h2000, 0, 1);
        reg_wr = 1; reg_addr = 0; reg_wdata = B27;
        tick();
        chk("R8 same cycle old ctrl", {31'b0, evt_req}, 0);
        retire(0, 0, 32'h2010, 0, 2);
        tick();
        chk("R8 next cycle new ctrl", {31'b0, evt_req}, 1);
        chk("R8 ret", evt_ret, 32'h2014);

        // R9 retire while held is ignored; clear status while held
        wr(1, 32'hFFFF_FFFF);
        retire(0, 0, 32'h3000, 0, 3);
        tick();
        chk("R9 still held", {31'b0, evt_req}, 1);
        chk("R9 ret stable", evt_ret, 32'h2014);
        rd(1, d);
        chk("R9 status untouched", d, 0);
        do_ack();
        chk("R9 released", {31'b0, evt_req}, 0);
        do_ack();
        chk("R9 idle ack", {31'b0, evt_req}, 0);

        // R6 set wins over clear in the same cycle
        retire(0, 0, 32'h4000, 0, 4);
        reg_wr = 1; reg_addr = 1; reg_wdata = B27;
        tick();
        rd(1, d);
        chk("R6 set wins", d, B27);
        do_ack();

        // R6 write-one-to-clear only the written bit
        wr(0, B26);
        retire(1, 1, 32'h5000, 32'h9000, 5);
        tick();
        do_ack();
        rd(1, d);
        chk("R6 both sticky", d, B27 | B26);
        wr(1, B26);
        rd(1, d);
        chk("R6 partial clear", d, B27);
        wr(1, 0);
        rd(1, d);
        chk("R6 zero write keeps", d, B27);

        // R7 capture beats software write of saved address
        wr(0, B27);
        retire(0, 0, 32'h6000, 0, 6);
        reg_wr = 1; reg_addr = 2; reg_wdata = 32'h1234_0000;
        tick();
        rd(2, d);
        chk("R7 capture wins", d, 32'h6004);
        do_ack();
        wr(2, 32'h1234_0000);
        rd(2, d);
        chk("R10 save addr rw", d, 32'h1234_0000);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule